// File: doc/BRIEF.md
# Latency-Hiding Read Wrapper

This block sits in front of a synchronous read memory whose data comes back a fixed number of cycles after the address. It turns that memory into a decoupled read port. A producer offers addresses with a valid/ready handshake, and a consumer takes the returned words whenever it is ready. Read data never waits inside the memory. It is written into a small response FIFO on the one cycle it comes out of the memory pipeline.

No word can be lost, because a credit counter books one FIFO slot for each accepted read, and it does so at request time. A request is taken only while a slot is free. The booking is released when the consumer dequeues. Reads are fully pipelined, and with enough depth the wrapper accepts one read per cycle while the consumer drains one per cycle.

The memory model is a read-only latency model. The word stored at address `a` is the address inverted in the upper half and the address itself in the lower half.

Top module: `lhw_wrapper`

## Requirements
- R1: After reset, reqReady is 1 and rspValid is 0.
- R2: An accepted read of address A (ADDR_W bits) returns rspData = {~A, A}. rspValid stays 0 for LATENCY cycles after the accepting edge and is 1 one cycle later, at LATENCY+1 cycles after the accepting edge.
- R3: With reqValid held high and rspDeq held high, the wrapper accepts one read per cycle without dropping reqReady, provided DEPTH >= LATENCY+2. The responses come out on consecutive cycles.
- R4: reqReady is 0 while the booked-or-held count equals DEPTH. A request offered while reqReady is 0 is not accepted and yields no response.
- R5: A dequeue from a full wrapper frees one credit, and reqReady is 1 on the following cycle.
- R6: An accept and a dequeue in the same cycle leave the credit count unchanged.
- R7: Responses leave in request order, and none is lost while the consumer stalls with every slot booked.
- R8: rspDeq asserted while rspValid is 0 has no effect: the credit count does not underflow, and later reads behave normally.
- R9: rspValid is 1 only when at least one credit is booked and the FIFO holds a captured word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | Read request offered |
| reqAddr | input | ADDR_W | Read address |
| reqReady | output | 1 | A response slot is free, so a request is taken |
| rspValid | output | 1 | rspData holds the oldest response |
| rspData | output | 2*ADDR_W | Oldest returned word |
| rspDeq | input | 1 | Consumer removes the oldest response |

## Verification
A read taken on a clock edge shows rspValid exactly LATENCY+1 edges later. The bench checks that rspValid is still low at LATENCY edges and high with the right word at LATENCY+1 edges. Credit effects of an accept or a dequeue are visible on reqReady one edge later, and every such check samples at the falling edge that follows. In the streaming run, each response is matched against its request by position, and the gap between the first and last response must be exactly seven cycles.

// File: rtl/lhw_pkg.sv
package lhw_pkg;
  typedef struct packed {
    logic accept;
    logic capture;
    logic deq;
  } lhwStrobes_t;
endpackage

// File: rtl/lhw_ctrl.sv
module lhw_ctrl
  import lhw_pkg::*;
#(
  parameter int LATENCY = 3,
  parameter int DEPTH   = 5,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic             rspDeq,
  input  logic [CNT_W-1:0] fifoCnt,
  output logic             reqReady,
  output logic             rspValid,
  output lhwStrobes_t      strobes
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0]   credit;
  logic [LATENCY-1:0] vPipe;
  logic               accept;
  logic               deq;

  assign reqReady = credit < FULL;
  assign accept   = reqValid & reqReady;
  assign rspValid = (credit != '0) && (fifoCnt != '0);
  assign deq      = rspDeq & rspValid;

  assign strobes.accept  = accept;
  assign strobes.deq     = deq;
  assign strobes.capture = vPipe[LATENCY-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      credit <= '0;
    end else begin
      case ({accept, deq})
        2'b10:   credit <= credit + 1'b1;
        2'b01:   credit <= credit - 1'b1;
        default: credit <= credit;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vPipe <= '0;
    end else begin
      vPipe[0] <= accept;
      for (int i = 1; i < LATENCY; i++) vPipe[i] <= vPipe[i-1];
    end
  end

  p_credit_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    credit <= FULL);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && deq |=> credit == $past(credit));
  p_capture_booked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.capture |-> credit != '0);
  p_fifo_within_credit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifoCnt <= credit);
endmodule

// File: rtl/lhw_datapath.sv
module lhw_datapath
  import lhw_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LATENCY = 3,
  parameter int DEPTH   = 5,
  localparam int DATA_W = 2 * ADDR_W,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reqAddr,
  input  lhwStrobes_t       strobes,
  output logic [DATA_W-1:0] rspData,
  output logic [CNT_W-1:0]  fifoCnt
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] memPipe [LATENCY];
  logic [DATA_W-1:0] slots   [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [DATA_W-1:0] readWord(input logic [ADDR_W-1:0] a);
    return {~a, a};
  endfunction

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  // latency-N memory model: one stage per cycle of read latency
  always_ff @(posedge clk) begin
    if (strobes.accept) memPipe[0] <= readWord(reqAddr);
    for (int i = 1; i < LATENCY; i++) memPipe[i] <= memPipe[i-1];
  end

  always_ff @(posedge clk) begin
    if (strobes.capture) slots[wrPtr] <= memPipe[LATENCY-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      fifoCnt <= '0;
    end else begin
      if (strobes.capture) wrPtr <= bump(wrPtr);
      if (strobes.deq)     rdPtr <= bump(rdPtr);
      case ({strobes.capture, strobes.deq})
        2'b10:   fifoCnt <= fifoCnt + 1'b1;
        2'b01:   fifoCnt <= fifoCnt - 1'b1;
        default: fifoCnt <= fifoCnt;
      endcase
    end
  end

  assign rspData = slots[rdPtr];

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.capture |-> fifoCnt < CNT_W'(DEPTH));
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.deq |-> fifoCnt != '0);
endmodule

// File: rtl/lhw_wrapper.sv
module lhw_wrapper
  import lhw_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LATENCY = 3,
  parameter int DEPTH   = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reqValid,
  input  logic [ADDR_W-1:0]     reqAddr,
  output logic                  reqReady,
  output logic                  rspValid,
  output logic [2*ADDR_W-1:0]   rspData,
  input  logic                  rspDeq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  lhwStrobes_t      strobes;
  logic [CNT_W-1:0] fifoCnt;

  lhw_ctrl #(.LATENCY(LATENCY), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .rspDeq(rspDeq),
    .fifoCnt(fifoCnt), .reqReady(reqReady), .rspValid(rspValid),
    .strobes(strobes)
  );

  lhw_datapath #(.ADDR_W(ADDR_W), .LATENCY(LATENCY), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .reqAddr(reqAddr), .strobes(strobes),
    .rspData(rspData), .fifoCnt(fifoCnt)
  );
endmodule

// File: tb/lhw_wrapper_bench.sv
module lhw_wrapper_bench;
  localparam int LAT = 3;
  localparam int DEP = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [7:0]  reqAddr = '0;
  logic        reqReady, rspValid;
  logic [15:0] rspData;
  logic        rspDeq = 1'b0;

  int nChecks = 0;
  int nFails  = 0;

  // stimulus address and expected word, per R2
  localparam logic [23:0] VEC [6] = '{24'h00_FF00, 24'hFF_00FF, 24'h5A_A55A,
                                      24'hA5_5AA5, 24'h01_FE01, 24'h80_7F80};

  lhw_wrapper #(.ADDR_W(8), .LATENCY(LAT), .DEPTH(DEP)) u_lhw_wrapper (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqReady(reqReady), .rspValid(rspValid), .rspData(rspData), .rspDeq(rspDeq)
  );

  always #5 clk = ~clk;

  function automatic logic [15:0] expWord(input logic [7:0] a);
    return {~a, a};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic deqOne();
    rspDeq = 1'b1;
    @(posedge clk); #1;
    rspDeq = 1'b0;
  endtask

  task automatic singleRead(input logic [7:0] a, input logic [15:0] e, input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a;
    @(posedge clk); #1;
    reqValid = 1'b0;
    repeat (LAT) @(negedge clk);
    chk(!rspValid, {tag, " early valid"}, 32'(rspValid), 0);
    @(negedge clk);
    chk(rspValid && rspData == e, {tag, " data"}, {15'd0, rspValid, rspData}, {16'd1, e});
    deqOne();
    @(negedge clk);
    chk(!rspValid && reqReady, {tag, " drained"}, {rspValid, reqReady}, 32'b01);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] seq [5];
    int got, first, last;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(reqReady && !rspValid, "R1 reset", {reqReady, rspValid}, 32'b10);

    // R2: table of single reads
    for (int v = 0; v < 6; v++) singleRead(VEC[v][23:16], VEC[v][15:0], "R2");

    // R4/R7/R5/R6: fill every slot with the consumer stalled
    for (int i = 0; i < DEP; i++) begin
      @(negedge clk);
      chk(reqReady, "R4 ready while filling", 32'(reqReady), 1);
      reqValid = 1'b1; reqAddr = 8'h10 + 8'(i);
      @(posedge clk); #1;
    end
    reqValid = 1'b0;
    @(negedge clk);
    chk(!reqReady, "R4 not ready when full", 32'(reqReady), 0);
    reqValid = 1'b1; reqAddr = 8'hEE;
    repeat (3) @(posedge clk); #1;
    reqValid = 1'b0;
    repeat (LAT + 2) @(negedge clk);
    chk(rspValid && rspData == expWord(8'h10), "R7 oldest first", rspData, expWord(8'h10));
    chk(!reqReady, "R4 still full", 32'(reqReady), 0);
    deqOne();
    @(negedge clk);
    chk(reqReady, "R5 credit freed", 32'(reqReady), 1);
    chk(rspData == expWord(8'h11), "R7 second", rspData, expWord(8'h11));
    reqValid = 1'b1; reqAddr = 8'h20; rspDeq = 1'b1;
    @(posedge clk); #1;
    reqValid = 1'b0; rspDeq = 1'b0;
    @(negedge clk);
    chk(reqReady, "R6 accept+deq keeps count", 32'(reqReady), 1);
    chk(rspData == expWord(8'h12), "R7 third", rspData, expWord(8'h12));
    reqValid = 1'b1; reqAddr = 8'h21;
    @(posedge clk); #1;
    reqValid = 1'b0;
    @(negedge clk);
    chk(!reqReady, "R6 full again", 32'(reqReady), 0);
    repeat (LAT + 2) @(negedge clk);
    seq = '{8'h12, 8'h13, 8'h14, 8'h20, 8'h21};
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(rspValid && rspData == expWord(seq[k]), "R7 drain order", rspData, expWord(seq[k]));
      deqOne();
    end
    repeat (LAT + 3) @(negedge clk);
    chk(!rspValid && reqReady, "R4 ignored request gave nothing", {rspValid, reqReady}, 32'b01);

    // R8: dequeue with nothing held
    @(negedge clk);
    rspDeq = 1'b1;
    repeat (3) @(posedge clk); #1;
    rspDeq = 1'b0;
    @(negedge clk);
    chk(reqReady && !rspValid, "R8 stray deq ignored", {reqReady, rspValid}, 32'b10);
    singleRead(8'h77, expWord(8'h77), "R8");

    // R3: streaming at one read per cycle
    got = 0; first = -1; last = -1;
    rspDeq = 1'b1;
    for (int it = 0; it < 8 + LAT + 3; it++) begin
      @(negedge clk);
      if (rspValid) begin
        chk(rspData == expWord(8'h40 + 8'(got)), "R3 stream data", rspData, expWord(8'h40 + 8'(got)));
        if (first < 0) first = it;
        last = it;
        got++;
      end
      if (it < 8) begin
        chk(reqReady, "R3 no stall", 32'(reqReady), 1);
        reqValid = 1'b1; reqAddr = 8'h40 + 8'(it);
      end else begin
        reqValid = 1'b0;
      end
    end
    rspDeq = 1'b0;
    chk(got == 8, "R3 count", got, 8);
    chk(last - first == 7, "R3 back-to-back", last - first, 7);
    chk(first == LAT + 1, "R9 first valid after capture", first, LAT + 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule